// File: doc/BRIEF.md
# Registered Bit Manipulation Unit

This block is a single-stage datapath for bit-level work on 32-bit words. Each cycle it may take one opcode and two operands, `x` and `y`, under a valid strobe. On the next clock edge it presents the answer together with a valid flag. No operation stalls the unit, so a new request can be issued every cycle.

The operations fall into three families:

- **Shifts and rotates.** They use only the low five bits of `y` as the amount.
- **Field operations.** These are highest-set-bit encode, one-hot decode, low-bit mask, population count, partial bit reversal, and sign or zero extension from a chosen bit.
- **Comparisons.** They return all-ones for true and zero for false. A three-way signed compare returns -1, 0 or +1.

A control path selects an operation by its opcode, and the block returns the word one cycle later.

Top module: `bitop_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_result` holds that operation's result; strobes on consecutive cycles each produce their own result one cycle later.
- R2: When `in_valid` is low at a rising edge, `out_valid` is low after it and `out_result` keeps its previous value whatever `in_op`, `in_x` and `in_y` carry.
- R3: Opcode 0 shifts `x` right and opcode 1 shifts it left, filling with zeros, by `y[4:0]`; amounts of 32 or more act as the amount modulo 32.
- R4: Opcode 2 shifts `x` right by `y[4:0]`, filling vacated bits with copies of bit 31.
- R5: Opcode 3 rotates `x` right and opcode 4 rotates it left by `y[4:0]`.
- R6: Opcode 5 returns the index (0 to 31) of the highest set bit of `x`; an `x` of 0 returns 0.
- R7: Opcode 6 returns a word with only bit `y[4:0]` set; opcode 7 returns a word with bits 0 through `y[4:0]` set.
- R8: Opcode 8 returns the number of set bits in `x`.
- R9: Opcode 9 places bit `y[4:0]-i` of `x` at bit `i` for `i` up to `y[4:0]` and clears all bits above `y[4:0]`.
- R10: Opcode 10 keeps bits 0 through `y[4:0]` of `x` and copies bit `y[4:0]` into every higher bit; opcode 11 keeps the same bits and clears every higher bit.
- R11: Opcodes 12 to 21 compare `x` with `y` and return 0xFFFFFFFF for true and 0 for false, as follows:
  - 12: signed less-than
  - 13: unsigned less-than
  - 14: signed less-or-equal
  - 15: unsigned less-or-equal
  - 16: signed greater-than
  - 17: unsigned greater-than
  - 18: signed greater-or-equal
  - 19: unsigned greater-or-equal
  - 20: equal
  - 21: not equal
- R12: Opcode 22 compares `x` with `y` as signed values and returns 0xFFFFFFFF if `x<y`, 0 if equal, and 1 if `x>y`.
- R13: Opcodes 23 to 31 return a result of 0 with `out_valid` still asserted.
- R14: While `rst_n` is low, `out_valid` and `out_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 5 | Operation code |
| in_x | input | 32 | First operand |
| in_y | input | 32 | Second operand, amount or bit index |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Registered result |

## Verification
Two events can fall in the same clock edge: the capture of a new request and the release of the previous result. The bench provokes this with long runs of strobes on consecutive cycles. Each run uses random opcodes and operands and is broken by idle cycles that carry junk operands.

At every falling edge the bench checks that the output carries exactly the result of the request issued one cycle earlier. When the prior cycle was idle, it checks that the output carries the last valid result instead. Directed cases cover the following:

- shift amounts of 31, 32 and 33
- encode of zero and one
- the full-width mask and reversal
- the signed/unsigned split at 0x80000000

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [4:0] {
      OP_SHR  = 5'd0,  OP_SHL  = 5'd1,  OP_SAR  = 5'd2,  OP_ROR  = 5'd3,
      OP_ROL  = 5'd4,  OP_ENC  = 5'd5,  OP_DEC  = 5'd6,  OP_MSK  = 5'd7,
      OP_ONES = 5'd8,  OP_REV  = 5'd9,  OP_SGNX = 5'd10, OP_ZROX = 5'd11,
      OP_LTS  = 5'd12, OP_LTU  = 5'd13, OP_LES  = 5'd14, OP_LEU  = 5'd15,
      OP_GTS  = 5'd16, OP_GTU  = 5'd17, OP_GES  = 5'd18, OP_GEU  = 5'd19,
      OP_EQ   = 5'd20, OP_NE   = 5'd21, OP_CMP3 = 5'd22
   } bitop_e;

   localparam int unsigned OP_BITS = 5;
   localparam int unsigned NUM_OPS = 23;
endpackage

// File: rtl/bitop_shift.sv
module bitop_shift
   import bitop_pkg::*;
#(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(W)
) (
   input  bitop_e           op,
   input  logic [W-1:0]     x,
   input  logic [SHW-1:0]   amt,
   output logic [W-1:0]     res
);
   logic           mine;
   logic           is_rot;
   logic [W-1:0]   core;

   assign is_rot = (op == OP_ROR) || (op == OP_ROL);
   assign mine   = (op == OP_SHR) || (op == OP_SHL) || (op == OP_SAR) || is_rot;

   function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
      for (int i = 0; i < W; i++) mirror[i] = v[W-1-i];
   endfunction

   if (BARREL) begin : g_barrel
      // left operations ride the right-going stages on a mirrored word
      logic           go_left;
      logic           fill_bit;
      logic [W-1:0]   stg [SHW+1];

      assign go_left  = (op == OP_SHL) || (op == OP_ROL);
      assign fill_bit = (op == OP_SAR) ? x[W-1] : 1'b0;
      assign stg[0]   = go_left ? mirror(x) : x;

      for (genvar i = 0; i < SHW; i++) begin : g_stage
         localparam int S = 1 << i;
         logic [S-1:0] fill_w;
         assign fill_w     = is_rot ? stg[i][S-1:0] : {S{fill_bit}};
         assign stg[i+1]   = amt[i] ? {fill_w, stg[i][W-1:S]} : stg[i];
      end

      assign core = go_left ? mirror(stg[SHW]) : stg[SHW];
   end else begin : g_behav
      int unsigned back;
      assign back = W - int'(amt);
      always_comb begin
         unique case (op)
            OP_SHR:  core = x >> amt;
            OP_SHL:  core = x << amt;
            OP_SAR:  core = W'($signed(x) >>> amt);
            OP_ROR:  core = (x >> amt) | (x << back);
            OP_ROL:  core = (x << amt) | (x >> back);
            default: core = '0;
         endcase
      end
   end

   assign res = mine ? core : '0;

   always_comb begin
      // R5
      if (is_rot) begin
         rot_popcount_chk: assert ($countones(res) == $countones(x));
      end
   end
endmodule

// File: rtl/bitop_field.sv
module bitop_field
   import bitop_pkg::*;
#(
   parameter int W    = 32,
   localparam int SHW = $clog2(W)
) (
   input  bitop_e           op,
   input  logic [W-1:0]     x,
   input  logic [SHW-1:0]   amt,
   output logic [W-1:0]     res
);
   logic [SHW-1:0]  top_idx;
   logic [SHW:0]    pop;
   logic [W-1:0]    keep_mask;
   logic [W-1:0]    flipped;
   logic [W-1:0]    dec_word;

   always_comb begin
      top_idx = '0;
      for (int i = 0; i < W; i++) if (x[i]) top_idx = SHW'(i);
   end

   always_comb begin
      pop = '0;
      for (int i = 0; i < W; i++) pop = pop + {{SHW{1'b0}}, x[i]};
   end

   always_comb begin
      for (int i = 0; i < W; i++) flipped[i] = x[W-1-i];
   end

   // W-1-amt equals ~amt in SHW bits because W is a power of two
   assign keep_mask = {W{1'b1}} >> (~amt);
   assign dec_word  = {{(W-1){1'b0}}, 1'b1} << amt;

   always_comb begin
      unique case (op)
         OP_ENC:  res = W'(top_idx);
         OP_DEC:  res = dec_word;
         OP_MSK:  res = keep_mask;
         OP_ONES: res = W'(pop);
         OP_REV:  res = flipped >> (~amt);
         OP_SGNX: res = x[amt] ? (x | ~keep_mask) : (x & keep_mask);
         OP_ZROX: res = x & keep_mask;
         default: res = '0;
      endcase
   end

   always_comb begin
      // R6
      if (x != '0) begin
         enc_hit_chk: assert (x[top_idx] && ((x >> top_idx) >> 1) == '0);
      end
      // R7
      dec_onehot_chk: assert ($onehot(dec_word) && $countones(keep_mask) == int'(amt) + 1);
   end
endmodule

// File: rtl/bitop_cmp.sv
module bitop_cmp
   import bitop_pkg::*;
#(
   parameter int W = 32
) (
   input  bitop_e         op,
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [W-1:0]   res
);
   logic lts, ltu, eq, gts;
   logic hit;

   assign lts = $signed(x) < $signed(y);
   assign ltu = x < y;
   assign eq  = x == y;
   assign gts = $signed(y) < $signed(x);

   always_comb begin
      hit = 1'b0;
      unique case (op)
         OP_LTS: hit = lts;
         OP_LTU: hit = ltu;
         OP_LES: hit = lts | eq;
         OP_LEU: hit = ltu | eq;
         OP_GTS: hit = ~(lts | eq);
         OP_GTU: hit = ~(ltu | eq);
         OP_GES: hit = ~lts;
         OP_GEU: hit = ~ltu;
         OP_EQ:  hit = eq;
         OP_NE:  hit = ~eq;
         default: hit = 1'b0;
      endcase
   end

   always_comb begin
      if (op == OP_CMP3)       res = lts ? {W{1'b1}} : (eq ? '0 : W'(1));
      else if (hit)            res = {W{1'b1}};
      else                     res = '0;
   end

   always_comb begin
      // R12
      order_excl_chk: assert ($onehot({lts, eq, gts}));
   end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int W      = 32,
   parameter bit BARREL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [OP_BITS-1:0]   in_op,
   input  logic [W-1:0]         in_x,
   input  logic [W-1:0]         in_y,
   output logic                 out_valid,
   output logic [W-1:0]         out_result
);
   localparam int SHW = $clog2(W);

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("bitop_unit: W must be a power of two of at least 8");
   end

   bitop_e          op;
   logic [SHW-1:0]  amt;
   logic [W-1:0]    r_shift, r_field, r_cmp, nxt;

   assign op  = bitop_e'(in_op);
   assign amt = in_y[SHW-1:0];

   bitop_shift #(.W(W), .BARREL(BARREL)) shift_i (
      .op(op), .x(in_x), .amt(amt), .res(r_shift));

   bitop_field #(.W(W)) field_i (
      .op(op), .x(in_x), .amt(amt), .res(r_field));

   bitop_cmp #(.W(W)) cmp_i (
      .op(op), .x(in_x), .y(in_y), .res(r_cmp));

   // each unit yields zero outside its own opcodes, so undefined codes give zero
   assign nxt = r_shift | r_field | r_cmp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_result <= nxt;
      end
   end

   // R1
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> out_result == $past(out_result));

   // R13
   undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid) && $past(in_op) >= OP_BITS'(NUM_OPS)) |-> (out_valid && out_result == '0));
endmodule

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  in_op = '0;
   logic [31:0] in_x = '0;
   logic [31:0] in_y = '0;
   logic        out_valid;
   logic [31:0] out_result;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bit          pend_v   = 1'b0;
   logic [4:0]  pend_op  = '0;
   logic [31:0] pend_exp = '0;
   logic [31:0] held_exp = '0;

   bitop_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_result(out_result));

   always #5 clk = ~clk;

   function automatic logic [31:0] ref_model(logic [4:0] op, logic [31:0] x, logic [31:0] y);
      int a = int'(y & 32'd31);
      logic [31:0] r = '0;
      logic lts = $signed(x) < $signed(y);
      logic ltu = x < y;
      case (op)
         5'd0:  r = x >> a;
         5'd1:  r = x << a;
         5'd2:  begin r = x; repeat (a) r = {r[31], r[31:1]}; end
         5'd3:  begin r = x; repeat (a) r = {r[0], r[31:1]}; end
         5'd4:  begin r = x; repeat (a) r = {r[30:0], r[31]}; end
         5'd5:  for (int i = 0; i < 32; i++) if (x[i]) r = i;
         5'd6:  r[a] = 1'b1;
         5'd7:  for (int i = 0; i <= a; i++) r[i] = 1'b1;
         5'd8:  for (int i = 0; i < 32; i++) r = r + x[i];
         5'd9:  for (int i = 0; i <= a; i++) r[i] = x[a-i];
         5'd10: for (int i = 0; i < 32; i++) r[i] = (i <= a) ? x[i] : x[a];
         5'd11: for (int i = 0; i <= a; i++) r[i] = x[i];
         5'd12: r = lts ? '1 : '0;
         5'd13: r = ltu ? '1 : '0;
         5'd14: r = (lts || x == y) ? '1 : '0;
         5'd15: r = (ltu || x == y) ? '1 : '0;
         5'd16: r = ($signed(x) > $signed(y)) ? '1 : '0;
         5'd17: r = (x > y) ? '1 : '0;
         5'd18: r = ($signed(x) >= $signed(y)) ? '1 : '0;
         5'd19: r = (x >= y) ? '1 : '0;
         5'd20: r = (x == y) ? '1 : '0;
         5'd21: r = (x != y) ? '1 : '0;
         5'd22: r = lts ? 32'hFFFF_FFFF : ((x == y) ? 32'd0 : 32'd1);
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string req_of(logic [4:0] op);
      case (op)
         5'd0, 5'd1:  return "R3";
         5'd2:        return "R4";
         5'd3, 5'd4:  return "R5";
         5'd5:        return "R6";
         5'd6, 5'd7:  return "R7";
         5'd8:        return "R8";
         5'd9:        return "R9";
         5'd10, 5'd11: return "R10";
         5'd22:       return "R12";
         default:     return (op >= 5'd12 && op <= 5'd21) ? "R11" : "R13";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // one clock: judge the previous request, then drive the next one
   task automatic step(input bit v, input logic [4:0] op, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      if (pend_v) begin
         check("R1", {31'd0, out_valid}, 32'd1);
         check(req_of(pend_op), out_result, pend_exp);
         held_exp = pend_exp;
      end else begin
         check("R2", {31'd0, out_valid}, 32'd0);
         check("R2", out_result, held_exp);
      end
      in_valid = v;
      in_op    = op;
      in_x     = x;
      in_y     = y;
      pend_v   = v;
      pend_op  = op;
      pend_exp = ref_model(op, x, y);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R14", {31'd0, out_valid}, 32'd0);
      check("R14", out_result, 32'd0);
      rst_n = 1'b1;

      // directed corners, back to back
      step(1, 5'd0, 32'hF000_000F, 32'd32);    // R3 amount 32 acts as 0
      step(1, 5'd1, 32'h0000_0003, 32'd33);    // R3 amount 33 acts as 1
      step(1, 5'd0, 32'h8000_0000, 32'd31);    // R3
      step(1, 5'd2, 32'h8000_0010, 32'd4);     // R4
      step(1, 5'd2, 32'h4000_0000, 32'd63);    // R4
      step(1, 5'd3, 32'h0000_0001, 32'd1);     // R5
      step(1, 5'd4, 32'h8000_0001, 32'd36);    // R5
      step(1, 5'd5, 32'h0000_0000, 32'd0);     // R6 zero
      step(1, 5'd5, 32'h0000_0001, 32'd0);     // R6 one
      step(1, 5'd5, 32'h8000_0000, 32'd0);     // R6
      step(1, 5'd6, 32'd0, 32'd31);            // R7
      step(1, 5'd7, 32'd0, 32'd31);            // R7 full mask
      step(1, 5'd7, 32'd0, 32'd0);             // R7
      step(1, 5'd8, 32'hFFFF_FFFF, 32'd0);     // R8
      step(1, 5'd9, 32'h0000_0001, 32'd31);    // R9
      step(1, 5'd9, 32'hFFFF_FFF6, 32'd3);     // R9
      step(1, 5'd10, 32'h0000_0080, 32'd7);    // R10
      step(1, 5'd11, 32'hFFFF_FFFF, 32'd15);   // R10
      step(1, 5'd12, 32'h8000_0000, 32'd1);    // R11 signed true
      step(1, 5'd13, 32'h8000_0000, 32'd1);    // R11 unsigned false
      step(1, 5'd14, 32'd5, 32'd5);            // R11
      step(1, 5'd17, 32'h8000_0000, 32'd1);    // R11
      step(1, 5'd22, 32'h8000_0000, 32'd1);    // R12 -1
      step(1, 5'd22, 32'd7, 32'd7);            // R12 0
      step(1, 5'd22, 32'd1, 32'hFFFF_FFFF);    // R12 +1
      step(1, 5'd23, 32'hFFFF_FFFF, 32'd1);    // R13
      step(1, 5'd31, 32'h1234_5678, 32'd9);    // R13
      step(0, 5'd7, 32'hDEAD_BEEF, 32'd3);     // R2 idle with junk
      step(0, 5'd1, 32'h1111_1111, 32'd5);     // R2

      // random mix, mostly back to back
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] rx = $urandom;
         logic [31:0] ry = $urandom;
         if (($urandom % 4) == 0) ry = ry & 32'h3F;
         step(($urandom % 8) != 0, 5'($urandom % 32), rx, ry);
      end
      step(0, 5'd0, 32'd0, 32'd0);
      step(0, 5'd0, 32'd0, 32'd0);
      done = 1'b1;
      finish_run();
   end
endmodule